// File: doc/BRIEF.md
# Sixteen-Pin Shared GPIO Port with Masked Change Notification

This block models one general-purpose I/O port whose pins can be driven from two sides. The CPU side owns a 32-bit configuration word and a 16-bit output-data register. Attached devices supply their own drive-enable and drive-value vectors on separate inputs. The port merges both drives, plus an optional pull-up per pin, into one resolved level per pin. That level is what a read of the port returns.

Whenever the CPU writes the data or configuration register, the block compares the resolved levels just before and just after the write. If any level moved, it reports the set of changed pins. It also pulses a notify line for every registered watcher whose trigger mask covers at least one changed pin. Up to four watchers can be registered. Each watcher takes the lowest free slot, and registration is refused once every slot is taken.

A write of a nonzero value to the port's interrupt-control register is not supported, and the block flags it as a configuration error.

Top module: `gpio_watch_port`

## Requirements
- R1: In the configuration word (write select 1), bit 2n enables CPU drive of pin n and bit 2n+1 enables the pull-up of pin n.
- R2: Pin n resolves to (cpuDrive AND cpuData) OR (periphDir AND periphData) OR (pull-up AND NOT (cpuDrive OR periphDir)).
- R3: `pinLevel` shows the resolved levels, not the latched CPU data. A data bit on an undriven pin is not visible.
- R4: For a data write (select 0) or configuration write (select 1) that changes any resolved level, the cycle after the write shows `changedBits` equal to old XOR new levels. In that cycle, `notify[i]` is high exactly when slot i is registered and its mask overlaps `changedBits`.
- R5: A data or configuration write that leaves every resolved level unchanged produces no notify and a zero `changedBits`.
- R6: A slot whose mask does not overlap the changed set, and a slot that is not registered, does not notify.
- R7: A registration request takes the lowest free slot. The next cycle shows `regAck` together with that slot index. When all slots are in use, the next cycle shows `regFail` and no slot is taken.
- R8: A write to the interrupt-control register (select 2) with a nonzero value raises `cfgError` for one cycle. A zero value does not. Neither case changes pins or produces a notify.
- R9: A change on `periphDir` or `periphData` alone updates `pinLevel` but produces no notify and no `changedBits`.
- R10: Reset clears the configuration word, the data register and all watcher slots, so every pin resolves to 0 and no output is active.
- R11: Notify and `changedBits` last a single cycle unless another write follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | 0 data, 1 configuration, 2 interrupt control |
| wrData | input | 32 | Write value (data uses the low 16 bits) |
| periphDir | input | 16 | Device-side drive enables |
| periphData | input | 16 | Device-side drive values |
| regReq | input | 1 | Watcher registration request |
| regMask | input | 16 | Trigger mask of the registering watcher |
| regAck | output | 1 | Registration accepted (one cycle) |
| regFail | output | 1 | Registration refused, all slots full (one cycle) |
| regSlot | output | 2 | Slot granted, valid with regAck |
| pinLevel | output | 16 | Resolved pin levels |
| changedBits | output | 16 | Pins changed by the last write |
| notify | output | 4 | Per-slot change pulse |
| cfgError | output | 1 | Unsupported interrupt-control write |

## Verification
The bench goes after writes that do not move any level. Examples are setting a data bit on an undriven pin, and switching a pin from driven-high to pulled-up. A design that compared raw register contents instead of resolved levels would notify there. It also checks a pull-up that is overridden by device drive, which a design with the wrong merge would let through. It then checks the full-slot refusal and the lowest-slot reuse after reset; an off-by-one search would grant a fifth slot or skip slot 0. Finally, it checks that a device-side change alone stays silent, which a design that watched the levels continuously would break.

// File: rtl/gpio_watch_pkg.sv
package gpio_watch_pkg;
  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_CFG  = 2'd1,
    SEL_IRQ  = 2'd2,
    SEL_NONE = 2'd3
  } regSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic dataWr;
    logic cfgWr;
    logic slotLoad;
  } gpioStrobe_t;
endpackage

// File: rtl/gpio_watch_ctrl.sv
module gpio_watch_ctrl
  import gpio_watch_pkg::*;
#(
  parameter int PIN_COUNT = 16,
  parameter int WATCHERS  = 4,
  localparam int CFG_W    = 2 * PIN_COUNT,
  localparam int SLOT_W   = (WATCHERS > 1) ? $clog2(WATCHERS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrSel,
  input  logic [CFG_W-1:0]  wrData,
  input  logic              regReq,
  output gpioStrobe_t       strobe,
  output logic [SLOT_W-1:0] loadSlot,
  output logic              regAck,
  output logic              regFail,
  output logic [SLOT_W-1:0] regSlot,
  output logic              cfgError
);
  logic [WATCHERS-1:0] slotUsed;
  logic                freeFound;
  logic [SLOT_W-1:0]   freeIdx;
  regSel_e             selDec;

  assign selDec = regSel_e'(wrSel);

  // lowest free slot search
  always_comb begin
    freeFound = 1'b0;
    freeIdx   = '0;
    for (int i = WATCHERS - 1; i >= 0; i--) begin
      if (!slotUsed[i]) begin
        freeFound = 1'b1;
        freeIdx   = SLOT_W'(i);
      end
    end
  end

  always_comb begin
    strobe.dataWr   = wrEn && (selDec == SEL_DATA);
    strobe.cfgWr    = wrEn && (selDec == SEL_CFG);
    strobe.slotLoad = regReq && freeFound;
    loadSlot        = freeIdx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotUsed <= '0;
      regAck   <= 1'b0;
      regFail  <= 1'b0;
      regSlot  <= '0;
      cfgError <= 1'b0;
    end else begin
      regAck   <= regReq && freeFound;
      regFail  <= regReq && !freeFound;
      cfgError <= wrEn && (selDec == SEL_IRQ) && (|wrData);
      if (regReq && freeFound) begin
        slotUsed[freeIdx] <= 1'b1;
        regSlot           <= freeIdx;
      end
    end
  end
endmodule

// File: rtl/gpio_watch_dp.sv
module gpio_watch_dp
  import gpio_watch_pkg::*;
#(
  parameter int PIN_COUNT = 16,
  parameter int WATCHERS  = 4,
  localparam int CFG_W    = 2 * PIN_COUNT,
  localparam int SLOT_W   = (WATCHERS > 1) ? $clog2(WATCHERS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  gpioStrobe_t          strobe,
  input  logic [SLOT_W-1:0]    loadSlot,
  input  logic [CFG_W-1:0]     wrData,
  input  logic [PIN_COUNT-1:0] regMask,
  input  logic [PIN_COUNT-1:0] periphDir,
  input  logic [PIN_COUNT-1:0] periphData,
  output logic [PIN_COUNT-1:0] pinLevel,
  output logic [PIN_COUNT-1:0] changedBits,
  output logic [WATCHERS-1:0]  notify
);
  logic [CFG_W-1:0]     cfgWord, cfgNext;
  logic [PIN_COUNT-1:0] cpuData, dataNext;
  logic [PIN_COUNT-1:0] levelNow, levelNext, levelDiff;
  logic [PIN_COUNT-1:0] slotMask [WATCHERS];
  logic [WATCHERS-1:0]  hitVec;

  assign cfgNext  = strobe.cfgWr  ? wrData : cfgWord;
  assign dataNext = strobe.dataWr ? wrData[PIN_COUNT-1:0] : cpuData;

  // per-pin resolution, before and after the pending write
  for (genvar n = 0; n < PIN_COUNT; n++) begin : g_pin
    logic drvNow, pullNow, drvNxt, pullNxt;
    assign drvNow  = cfgWord[2*n];
    assign pullNow = cfgWord[2*n+1];
    assign drvNxt  = cfgNext[2*n];
    assign pullNxt = cfgNext[2*n+1];
    assign levelNow[n]  = (drvNow & cpuData[n]) | (periphDir[n] & periphData[n])
                        | (pullNow & ~(drvNow | periphDir[n]));
    assign levelNext[n] = (drvNxt & dataNext[n]) | (periphDir[n] & periphData[n])
                        | (pullNxt & ~(drvNxt | periphDir[n]));
  end

  assign levelDiff = levelNow ^ levelNext;
  assign pinLevel  = levelNow;

  for (genvar w = 0; w < WATCHERS; w++) begin : g_watch
    assign hitVec[w] = |(slotMask[w] & levelDiff);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        slotMask[w] <= '0;
      else if (strobe.slotLoad && (loadSlot == SLOT_W'(w)))
        slotMask[w] <= regMask;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgWord     <= '0;
      cpuData     <= '0;
      changedBits <= '0;
      notify      <= '0;
    end else begin
      cfgWord <= cfgNext;
      cpuData <= dataNext;
      if (strobe.dataWr || strobe.cfgWr) begin
        changedBits <= levelDiff;
        notify      <= hitVec;
      end else begin
        changedBits <= '0;
        notify      <= '0;
      end
    end
  end
endmodule

// File: rtl/gpio_watch_port.sv
module gpio_watch_port
  import gpio_watch_pkg::*;
#(
  parameter int PIN_COUNT = 16,
  parameter int WATCHERS  = 4,
  localparam int CFG_W    = 2 * PIN_COUNT,
  localparam int SLOT_W   = (WATCHERS > 1) ? $clog2(WATCHERS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [1:0]           wrSel,
  input  logic [CFG_W-1:0]     wrData,
  input  logic [PIN_COUNT-1:0] periphDir,
  input  logic [PIN_COUNT-1:0] periphData,
  input  logic                 regReq,
  input  logic [PIN_COUNT-1:0] regMask,
  output logic                 regAck,
  output logic                 regFail,
  output logic [SLOT_W-1:0]    regSlot,
  output logic [PIN_COUNT-1:0] pinLevel,
  output logic [PIN_COUNT-1:0] changedBits,
  output logic [WATCHERS-1:0]  notify,
  output logic                 cfgError
);
  gpioStrobe_t       strobe;
  logic [SLOT_W-1:0] loadSlot;

  gpio_watch_ctrl #(.PIN_COUNT(PIN_COUNT), .WATCHERS(WATCHERS)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .regReq(regReq), .strobe(strobe), .loadSlot(loadSlot),
    .regAck(regAck), .regFail(regFail), .regSlot(regSlot), .cfgError(cfgError)
  );

  gpio_watch_dp #(.PIN_COUNT(PIN_COUNT), .WATCHERS(WATCHERS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .loadSlot(loadSlot),
    .wrData(wrData), .regMask(regMask), .periphDir(periphDir),
    .periphData(periphData), .pinLevel(pinLevel),
    .changedBits(changedBits), .notify(notify)
  );
endmodule

// File: rtl/gpio_watch_port_chk.sv
module gpio_watch_port_chk #(
  parameter int PIN_COUNT = 16,
  parameter int WATCHERS  = 4,
  localparam int CFG_W    = 2 * PIN_COUNT,
  localparam int SLOT_W   = (WATCHERS > 1) ? $clog2(WATCHERS) : 1
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 wrEn,
  input logic [1:0]           wrSel,
  input logic [CFG_W-1:0]     wrData,
  input logic                 regReq,
  input logic                 regAck,
  input logic                 regFail,
  input logic [PIN_COUNT-1:0] changedBits,
  input logic [WATCHERS-1:0]  notify,
  input logic                 cfgError
);
  // a notify needs a moved pin
  assert_notify_has_change_R4: assert property (@(posedge clk) disable iff (!rstN)
    (|notify) |-> (|changedBits));

  // nothing moved, nobody told
  assert_silent_when_equal_R5: assert property (@(posedge clk) disable iff (!rstN)
    (changedBits == '0) |-> (notify == '0));

  // only data or configuration writes may report a change
  assert_quiet_without_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    (|changedBits) |-> $past(wrEn && (wrSel == 2'd0 || wrSel == 2'd1)));

  // pulse ends when no write follows
  assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    ((|notify) && !wrEn) |=> (notify == '0));

  assert_reg_exclusive_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(regAck && regFail));

  assert_reg_answers_request_R7: assert property (@(posedge clk) disable iff (!rstN)
    (regAck || regFail) |-> $past(regReq));

  assert_cfg_error_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    cfgError |-> $past(wrEn && wrSel == 2'd2 && wrData != '0));
endmodule

bind gpio_watch_port gpio_watch_port_chk #(.PIN_COUNT(PIN_COUNT), .WATCHERS(WATCHERS)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
  .regReq(regReq), .regAck(regAck), .regFail(regFail),
  .changedBits(changedBits), .notify(notify), .cfgError(cfgError)
);

// File: tb/test_gpio_watch_port.sv
module test_gpio_watch_port;
  localparam int P = 16;
  localparam int W = 4;
  localparam int NVEC = 11;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] wrSel = 2'd3;
  logic [31:0] wrData = '0;
  logic [P-1:0] periphDir = '0, periphData = '0;
  logic regReq = 1'b0;
  logic [P-1:0] regMask = '0;
  logic regAck, regFail, cfgError;
  logic [1:0] regSlot;
  logic [P-1:0] pinLevel, changedBits;
  logic [W-1:0] notify;

  int checks = 0;
  int failures = 0;
  logic [31:0] mCfg = '0;
  logic [P-1:0] mData = '0;
  logic [P-1:0] mMask [W];

  always #10 clk = ~clk;

  gpio_watch_port i_gpio_watch_port (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .periphDir(periphDir), .periphData(periphData), .regReq(regReq),
    .regMask(regMask), .regAck(regAck), .regFail(regFail), .regSlot(regSlot),
    .pinLevel(pinLevel), .changedBits(changedBits), .notify(notify),
    .cfgError(cfgError)
  );

  // {sel, value, periphDir, periphData}
  localparam logic [65:0] VEC [NVEC] = '{
    {2'd1, 32'h0000_0001, 16'h0000, 16'h0000},  // pin0 driven, data 0: no move
    {2'd0, 32'h0000_0001, 16'h0000, 16'h0000},  // pin0 high
    {2'd1, 32'h0000_0002, 16'h0000, 16'h0000},  // drive -> pull-up, still high
    {2'd1, 32'h0000_0000, 16'h0000, 16'h0000},  // pin0 falls
    {2'd1, 32'hAAAA_AAAA, 16'h0000, 16'h0000},  // all pulled up
    {2'd0, 32'h0000_00F0, 16'h0000, 16'h0000},  // data on undriven pins
    {2'd1, 32'h5555_5555, 16'h0000, 16'h0000},  // all driven by CPU
    {2'd0, 32'h0000_00F0, 16'h0F00, 16'h0300},  // same data, device drives
    {2'd1, 32'h0000_0000, 16'h0F00, 16'h0300},  // CPU releases
    {2'd1, 32'h00AA_0000, 16'h0F00, 16'h0300},  // pull-ups hidden by device
    {2'd1, 32'h0000_0008, 16'h0000, 16'h0000}   // pin1 pull-up alone
  };

  function automatic logic [P-1:0] model(input logic [31:0] c, input logic [P-1:0] d,
                                         input logic [P-1:0] pd, input logic [P-1:0] pv);
    logic [P-1:0] r;
    for (int k = 0; k < P; k++) begin
      if (c[2*k])          r[k] = d[k] | (pd[k] & pv[k]);
      else if (pd[k])      r[k] = pv[k];
      else                 r[k] = c[2*k+1];
    end
    return r;
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [1:0] sel, input logic [31:0] val, input string req);
    logic [P-1:0] oldL, newL, diff;
    logic [W-1:0] expN;
    oldL = model(mCfg, mData, periphDir, periphData);
    if (sel == 2'd0) mData = val[P-1:0];
    if (sel == 2'd1) mCfg = val;
    newL = model(mCfg, mData, periphDir, periphData);
    diff = (sel <= 2'd1) ? (oldL ^ newL) : '0;
    for (int i = 0; i < W; i++) expN[i] = |(mMask[i] & diff);
    wrEn = 1'b1; wrSel = sel; wrData = val;
    @(negedge clk);
    wrEn = 1'b0; wrSel = 2'd3; wrData = '0;
    check(pinLevel == newL, {req, " level"}, 32'(pinLevel), 32'(newL));
    check(changedBits == diff, {req, " changed"}, 32'(changedBits), 32'(diff));
    check(notify == expN, {req, " notify"}, 32'(notify), 32'(expN));
  endtask

  task automatic doReg(input logic [P-1:0] m, input logic expOk, input logic [1:0] expSlot);
    regReq = 1'b1; regMask = m;
    @(negedge clk);
    regReq = 1'b0;
    check(regAck == expOk && regFail == !expOk, "R7 ack/fail", {30'd0, regAck, regFail},
          {30'd0, expOk, !expOk});
    if (expOk) begin
      check(regSlot == expSlot, "R7 slot", 32'(regSlot), 32'(expSlot));
      mMask[expSlot] = m;
    end
  endtask

  initial begin
    for (int i = 0; i < W; i++) mMask[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(pinLevel == '0, "R10 level", 32'(pinLevel), 0);
    check(notify == '0 && changedBits == '0 && !cfgError, "R10 outputs",
          {cfgError, notify, changedBits}, 0);

    // R7 registration in order, then full
    doReg(16'h000F, 1'b1, 2'd0);
    doReg(16'h00F0, 1'b1, 2'd1);
    doReg(16'h0F00, 1'b1, 2'd2);
    doReg(16'hF000, 1'b1, 2'd3);
    doReg(16'hFFFF, 1'b0, 2'd0);

    // R1 R2 R3 R4 R5 R6 vector walk
    for (int v = 0; v < NVEC; v++) begin
      periphDir  = VEC[v][31:16];
      periphData = VEC[v][15:0];
      #1;
      doWrite(VEC[v][65:64], VEC[v][63:32], $sformatf("R4 vec%0d", v));
    end

    // R11 pulse gone one cycle later
    doWrite(2'd1, 32'h5555_5555, "R11 setup");
    @(negedge clk);
    check(notify == '0 && changedBits == '0, "R11 pulse end", {notify, changedBits}, 0);

    // R9 device-only change
    periphDir = 16'hFFFF; periphData = 16'h1234;
    #1;
    check(pinLevel == model(mCfg, mData, periphDir, periphData), "R9 level follows",
          32'(pinLevel), 32'(model(mCfg, mData, periphDir, periphData)));
    @(negedge clk);
    check(notify == '0 && changedBits == '0, "R9 no notify", {notify, changedBits}, 0);

    // R8 interrupt-control writes
    wrEn = 1'b1; wrSel = 2'd2; wrData = 32'h0000_0100;
    @(negedge clk);
    wrEn = 1'b0; wrSel = 2'd3; wrData = '0;
    check(cfgError == 1'b1, "R8 nonzero flagged", 32'(cfgError), 1);
    check(notify == '0, "R8 no notify", 32'(notify), 0);
    @(negedge clk);
    check(cfgError == 1'b0, "R8 one cycle", 32'(cfgError), 0);
    doWrite(2'd2, 32'h0, "R8 zero");
    check(cfgError == 1'b0, "R8 zero not flagged", 32'(cfgError), 0);

    // R10 mid-run reset, then lowest slot again
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    periphDir = '0; periphData = '0;
    mCfg = '0; mData = '0;
    for (int i = 0; i < W; i++) mMask[i] = '0;
    #1;
    check(pinLevel == '0, "R10 after reset", 32'(pinLevel), 0);
    doReg(16'h0001, 1'b1, 2'd0);
    doWrite(2'd1, 32'h0000_0002, "R6 only slot0");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule